// File: doc/BRIEF.md
# Battery Temperature Rise-Rate Terminator

This block decides when a nickel-cell fast charge should stop because the pack is heating too quickly. A temperature measurement arrives as an unsigned code in tenths of a degree Celsius, marked by a one-cycle valid strobe. The block holds the most recent measurement. On each one-minute tick it subtracts the value it stored at the previous tick from that measurement, keeps the new value as the next reference, and compares the one-minute rise with a limit. A rise strictly greater than the limit latches a terminate flag, which stays set until clear or reset.

The limit depends on the cell chemistry and on the charge phase. Nickel-cadmium packs use 2.0 °C per minute. Nickel-metal-hydride packs use 1.5 °C per minute while the early window is open and 1.0 °C per minute otherwise. A charge cycle that started from automatic recharge always uses 1.0 °C per minute for nickel-metal-hydride. The charge controller opens the early window only for the first twelfth of the maximum fast-charge time, and only when the initial cell voltage was below the recharge level. A second sticky flag records that a nickel-metal-hydride termination happened outside the early window, so the controller can choose a top-off phase. Rate checking runs from the first tick of fast charge with no holdoff. It is suspended while the charge is paused and while no thermistor is fitted.

Top module: `trise_term`

## Requirements
- R1: After reset or a one-cycle `clr`, `term` and `term_late` are 0, the stored reference is dropped and the held sample is dropped.
- R2: The first qualifying tick after the reference was dropped only stores the reference and never sets `term`.
- R3: With `chem_nicd`=1 the limit is 20 tenths per minute: a rise of 21 sets `term` and a rise of 20 does not.
- R4: With `chem_nicd`=0, `early_win`=1 and `from_recharge`=0 the limit is 15 tenths per minute.
- R5: With `chem_nicd`=0, `early_win`=0 and `from_recharge`=0 the limit is 10 tenths per minute.
- R6: With `chem_nicd`=0 and `from_recharge`=1 the limit is 10 tenths per minute whatever `early_win` is.
- R7: A zero or negative one-minute change never sets `term`.
- R8: While `hold`=1, ticks leave `term` unchanged and the reference is dropped, so the first tick after `hold` clears only stores the reference.
- R9: While `therm_ok`=0, ticks leave `term` unchanged and the reference is dropped in the same way as in R8.
- R10: Once set, `term` stays 1 until `clr` or reset, whatever the later samples are.
- R11: When `term` is set, `term_late` is set in the same cycle if and only if `chem_nicd`=0 and `early_win`=0 at that tick. It holds until `clr` or reset.
- R12: A tick uses the newest sample, including one whose `temp_vld` falls in the same cycle as the tick.
- R13: A tick with no sample since reset or `clr` stores no reference.
- R14: `term` rises on the clock edge that samples the deciding tick, so it is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code | input | 12 | Battery temperature, unsigned tenths of °C |
| temp_vld | input | 1 | One-cycle strobe marking a new `temp_code` |
| minute_tick | input | 1 | One-cycle strobe once per minute |
| chem_nicd | input | 1 | 1 selects nickel-cadmium, 0 selects nickel-metal-hydride |
| early_win | input | 1 | Early fast-charge window open (low-start cycles only) |
| from_recharge | input | 1 | Current cycle began from automatic recharge |
| therm_ok | input | 1 | Thermistor fitted, temperature input below the disable level |
| hold | input | 1 | Charge paused |
| clr | input | 1 | Synchronous clear of flags, reference and held sample |
| term | output | 1 | Sticky rise-rate termination |
| term_late | output | 1 | Sticky: termination was nickel-metal-hydride outside the early window |

## Verification
A corrupted reference or held sample shows up at the first tick after the next sample, because the one-minute difference is then wrong. It produces either a spurious `term` or a missed one in the following cycle. A wrong limit selection only shows for rises in the band between two limits, so the sweep covers every chemistry and phase combination with rises from -5 to +30 tenths. Each case is checked in the cycle after its tick. A pause or thermistor path that fails to drop the reference shows as a trip on the first tick after resume, which is exactly where the bench samples.

// File: rtl/trise_pkg.sv
package trise_pkg;

    typedef logic [7:0] rate_t;

    typedef enum logic {
        CHEM_NIMH = 1'b0,
        CHEM_NICD = 1'b1
    } chem_t;

    typedef struct packed {
        chem_t chem;
        logic  early;
        logic  recharge;
    } phase_t;

    // Rise limit in tenths of a degree per minute for the given phase.
    function automatic rate_t pick_limit(phase_t ph, rate_t l_nicd,
                                         rate_t l_early, rate_t l_base);
        if (ph.chem == CHEM_NICD)
            return l_nicd;
        else if (ph.recharge)
            return l_base;
        else if (ph.early)
            return l_early;
        else
            return l_base;
    endfunction

    // A trip counts as late when it is a hydride pack outside the early window.
    function automatic logic is_late(phase_t ph);
        return (ph.chem == CHEM_NIMH) && !ph.early;
    endfunction

endpackage

// File: rtl/trise_sample.sv
module trise_sample #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          vld,
    input  logic [TW-1:0] code,
    output logic          have,
    output logic [TW-1:0] latest
);
    logic [TW-1:0] held_q;
    logic          held_ok_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held_q    <= '0;
            held_ok_q <= 1'b0;
        end else if (vld) begin
            held_q    <= code;
            held_ok_q <= 1'b1;
        end
    end

    // A sample arriving with the tick is used straight away.
    assign latest = vld ? code : held_q;
    assign have   = vld | held_ok_q;

    // R13
    no_stale_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) && !vld |-> !have);

endmodule

// File: rtl/trise_limit.sv
module trise_limit
    import trise_pkg::*;
#(
    parameter int LIM_NICD  = 20,
    parameter int LIM_EARLY = 15,
    parameter int LIM_BASE  = 10
) (
    input  phase_t ph,
    output rate_t  lim,
    output logic   late
);
    localparam rate_t L_NICD  = rate_t'(LIM_NICD);
    localparam rate_t L_EARLY = rate_t'(LIM_EARLY);
    localparam rate_t L_BASE  = rate_t'(LIM_BASE);

    assign lim  = pick_limit(ph, L_NICD, L_EARLY, L_BASE);
    assign late = is_late(ph);

endmodule

// File: rtl/trise_rate.sv
module trise_rate
    import trise_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          hold,
    input  logic          therm_ok,
    input  logic          have,
    input  logic [TW-1:0] latest,
    input  rate_t         lim,
    input  logic          late_now,
    input  logic          chem_nicd,
    output logic          term,
    output logic          term_late
);
    localparam int PAD = TW + 1 - $bits(rate_t);

    logic [TW-1:0]    base_q;
    logic             base_ok_q;
    logic             term_q;
    logic             late_q;
    logic signed [TW:0] diff;
    logic signed [TW:0] lim_s;
    logic             suspended;
    logic             over;

    assign suspended = hold || !therm_ok;
    assign diff      = $signed({1'b0, latest}) - $signed({1'b0, base_q});
    assign lim_s     = $signed({{PAD{1'b0}}, lim});
    assign over      = base_ok_q && (diff > lim_s);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            base_q    <= '0;
            base_ok_q <= 1'b0;
            term_q    <= 1'b0;
            late_q    <= 1'b0;
        end else if (suspended) begin
            base_ok_q <= 1'b0;
        end else if (tick && have) begin
            base_q    <= latest;
            base_ok_q <= 1'b1;
            if (over && !term_q) begin
                term_q <= 1'b1;
                late_q <= late_now;
            end
        end
    end

    assign term      = term_q;
    assign term_late = late_q;

    // R10
    term_hold_chk: assert property (@(posedge clk) disable iff (rst)
        term && !clr |=> term);

    // R11
    late_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
        term_late |-> term);

    // R11
    nicd_never_late_chk: assert property (@(posedge clk) disable iff (rst)
        !term && chem_nicd && !clr |=> !term_late);

    // R8
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hold && !clr |=> term == $past(term));

    // R9
    therm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !therm_ok && !clr |=> term == $past(term));

    // R14
    trip_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(term) |-> $past(tick) && $past(base_ok_q));

endmodule

// File: rtl/trise_term.sv
module trise_term
    import trise_pkg::*;
#(
    parameter int TW        = 12,
    parameter int LIM_NICD  = 20,
    parameter int LIM_EARLY = 15,
    parameter int LIM_BASE  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp_code,
    input  logic          temp_vld,
    input  logic          minute_tick,
    input  logic          chem_nicd,
    input  logic          early_win,
    input  logic          from_recharge,
    input  logic          therm_ok,
    input  logic          hold,
    input  logic          clr,
    output logic          term,
    output logic          term_late
);
    phase_t        ph;
    rate_t         lim;
    logic          late_now;
    logic          have;
    logic [TW-1:0] latest;

    assign ph.chem     = chem_t'(chem_nicd);
    assign ph.early    = early_win;
    assign ph.recharge = from_recharge;

    trise_sample #(.TW(TW)) u_sample (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .vld    (temp_vld),
        .code   (temp_code),
        .have   (have),
        .latest (latest)
    );

    trise_limit #(
        .LIM_NICD  (LIM_NICD),
        .LIM_EARLY (LIM_EARLY),
        .LIM_BASE  (LIM_BASE)
    ) u_limit (
        .ph   (ph),
        .lim  (lim),
        .late (late_now)
    );

    trise_rate #(.TW(TW)) u_rate (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .tick      (minute_tick),
        .hold      (hold),
        .therm_ok  (therm_ok),
        .have      (have),
        .latest    (latest),
        .lim       (lim),
        .late_now  (late_now),
        .chem_nicd (chem_nicd),
        .term      (term),
        .term_late (term_late)
    );

    // R1
    clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !term && !term_late);

endmodule

// File: tb/trise_term_test.sv
`timescale 1ns/1ps
module trise_term_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] temp_code = '0;
    logic        temp_vld = 1'b0;
    logic        minute_tick = 1'b0;
    logic        chem_nicd = 1'b0;
    logic        early_win = 1'b0;
    logic        from_recharge = 1'b0;
    logic        therm_ok = 1'b1;
    logic        hold = 1'b0;
    logic        clr = 1'b0;
    logic        term;
    logic        term_late;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    trise_term uut (
        .clk(clk), .rst(rst), .temp_code(temp_code), .temp_vld(temp_vld),
        .minute_tick(minute_tick), .chem_nicd(chem_nicd), .early_win(early_win),
        .from_recharge(from_recharge), .therm_ok(therm_ok), .hold(hold),
        .clr(clr), .term(term), .term_late(term_late)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic put_sample(input int v);
        @(negedge clk);
        temp_code = 12'(v);
        temp_vld  = 1'b1;
        @(negedge clk);
        temp_vld  = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        minute_tick = 1'b1;
        @(negedge clk);
        minute_tick = 1'b0;
    endtask

    task automatic sample_and_tick(input int v);
        @(negedge clk);
        temp_code   = 12'(v);
        temp_vld    = 1'b1;
        minute_tick = 1'b1;
        @(negedge clk);
        temp_vld    = 1'b0;
        minute_tick = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(term, 1'b0, "R1 term after reset");
        chk(term_late, 1'b0, "R1 term_late after reset");

        // Sweep every chemistry/phase combination over a range of rises.
        for (int c = 0; c < 2; c++) begin
            for (int e = 0; e < 2; e++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int d = -5; d <= 30; d++) begin
                        int    lim;
                        logic  exp_t;
                        logic  exp_l;
                        string tag;
                        chem_nicd     = c[0];
                        early_win     = e[0];
                        from_recharge = r[0];
                        if (c == 1) begin
                            lim = 20; tag = "R3 nicd limit";
                        end else if (r == 1) begin
                            lim = 10; tag = "R6 recharge limit";
                        end else if (e == 1) begin
                            lim = 15; tag = "R4 early limit";
                        end else begin
                            lim = 10; tag = "R5 base limit";
                        end
                        if (d <= 0) tag = {tag, " / R7 no rise"};
                        exp_t = (d > lim);
                        exp_l = exp_t && (c == 0) && (e == 0);
                        do_clr();
                        put_sample(250);
                        tick();
                        chk(term, 1'b0, "R2 seeding tick");
                        put_sample(250 + d);
                        tick();
                        chk(term, exp_t, $sformatf("%s c=%0d e=%0d r=%0d d=%0d", tag, c, e, r, d));
                        chk(term_late, exp_l, $sformatf("R11 late c=%0d e=%0d r=%0d d=%0d", c, e, r, d));
                    end
                end
            end
        end

        // Base hydride settings for directed cases.
        chem_nicd = 1'b0; early_win = 1'b0; from_recharge = 1'b0;

        // R10: sticky until clear.
        do_clr();
        put_sample(300); tick();
        put_sample(320); tick();
        chk(term, 1'b1, "R10 trip");
        put_sample(200); tick();
        chk(term, 1'b1, "R10 held after cooler sample");
        do_clr();
        chk(term, 1'b0, "R1 term after clr");
        chk(term_late, 1'b0, "R1 term_late after clr");

        // R8: pause drops the reference.
        put_sample(250); tick();
        hold = 1'b1;
        put_sample(300); tick();
        chk(term, 1'b0, "R8 tick while paused");
        hold = 1'b0;
        tick();
        chk(term, 1'b0, "R8 first tick after pause only seeds");
        put_sample(311); tick();
        chk(term, 1'b1, "R8 trips after reseed");

        // R9: no thermistor drops the reference.
        do_clr();
        put_sample(250); tick();
        therm_ok = 1'b0;
        put_sample(300); tick();
        chk(term, 1'b0, "R9 tick without thermistor");
        therm_ok = 1'b1;
        tick();
        chk(term, 1'b0, "R9 first tick after thermistor returns");
        put_sample(311); tick();
        chk(term, 1'b1, "R9 trips after reseed");

        // R12: sample in the same cycle as the tick is the one used.
        do_clr();
        put_sample(250); tick();
        put_sample(255);
        sample_and_tick(261);
        chk(term, 1'b1, "R12 same-cycle sample used");

        // R13: tick without any sample stores nothing.
        do_clr();
        tick();
        put_sample(400); tick();
        chk(term, 1'b0, "R13 first real tick only seeds");
        put_sample(405); tick();
        chk(term, 1'b0, "R13 small rise after seed");

        // R14: term visible in the cycle right after the deciding tick.
        do_clr();
        put_sample(250); tick();
        put_sample(262);
        @(negedge clk);
        minute_tick = 1'b1;
        chk(term, 1'b0, "R14 term low before tick edge");
        @(negedge clk);
        minute_tick = 1'b0;
        chk(term, 1'b1, "R14 term high after tick edge");
        chk(term_late, 1'b1, "R11 late on base hydride trip");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule